// File: doc/BRIEF.md
# A/D Conversion Start Gating Controller

This block decides when an analog-to-digital converter receives a start pulse. Two sources can request a conversion: the output of an on-chip pacing timer, and an active-low convert input driven from outside the chip. Both pass through one shared gate flag. While the flag is open, a falling edge on either source produces exactly one single-cycle `convStart` pulse. While it is closed, the same edges are dropped.

The gate is opened in one of two ways. Software can write the software-trigger bit as 1. Alternatively, a rising edge on the external trigger input opens it, but only when hardware triggering is enabled. Software can close the gate again by writing the software-trigger bit as 0. The gate is also held shut while the count-limit output is high.

A built-in down-counter raises that count-limit output once a programmed number of conversions has been issued. This is controlled acquisition. In free-running acquisition the counter never stops the run, so only software ends it. A special mode code disarms acquisition outright, so that convert and trigger edges have no effect.

Every asynchronous input goes through a two-flop synchronizer before its edges are detected.

Top module: `adc_trig_gate`

## Requirements
- R1: While `gateOpen` is 1, a falling edge on `pacerIn` or on `convInN` produces one `convStart` pulse exactly one cycle wide. The pulse appears on the third rising clock edge after the input changes.
- R2: While `gateOpen` is 0, falling edges on `pacerIn` and `convInN` produce no `convStart` pulse.
- R3: While `limitOut` is 1, `gateOpen` stays 0. This holds whatever is written to the software-trigger bit and whatever edges arrive on `trigIn`.
- R4: A write to address 0 with bit 0 (software trigger) equal to 0 closes the gate. `gateOpen` reads 0 after the next clock edge, and this takes priority over a trigger edge in the same cycle.
- R5: While `limitOut` is 0, a write to address 0 with bit 0 equal to 1 opens the gate. `gateOpen` reads 1 after that clock edge.
- R6: While `limitOut` is 0 and the stored hardware-trigger enable is 1 (address 0, bit 1), a rising edge on `trigIn` opens the gate. With that enable bit at 0, `trigIn` edges leave the gate closed.
- R7: The stored free-run bit is address 0, bit 2. When it is 0 (controlled), every issued start decrements the counter. The start that takes the counter from 1 to 0 also raises `limitOut`, and later edges are ignored. A loaded count of 0 behaves as 1. When the free-run bit is 1, starts never raise `limitOut`.
- R8: A write to address 1 whose low 8 bits equal 0x78 raises `limitOut` after the next clock edge. Any other value written to address 1 reloads the counter from the count register and lowers `limitOut`. The count register is at address 2.
- R9: Falling edges on `pacerIn` and `convInN` that land in the same cycle produce a single `convStart` pulse.
- R10: After reset, `gateOpen` is 0, `limitOut` is 1 and `convStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 mode, 2 count |
| wrData | input | DATA_W | Register write data |
| pacerIn | input | 1 | Pacing timer output; a falling edge requests a conversion |
| convInN | input | 1 | External active-low convert input; a falling edge requests a conversion |
| trigIn | input | 1 | External trigger; a rising edge may open the gate |
| convStart | output | 1 | Single-cycle conversion start pulse |
| gateOpen | output | 1 | Effective gate flag |
| limitOut | output | 1 | Count-limit output; high means acquisition is stopped |

## Verification
The bench first writes the software-trigger bit while the block is disarmed. A design that latched that write would open the gate as soon as the counter was reloaded. The bench then drives both convert sources low in the same cycle; a design that ORs pulses per source would emit two starts. It runs a controlled acquisition of three starts and fires one more edge afterwards. An off-by-one counter, or a gate that stays open for a cycle after the limit rises, would let that extra start through. Free-running mode with a count of 1 catches a counter that decrements regardless of mode. A trigger edge seen with hardware triggering disabled, or while disarmed, catches a gate qualified by the wrong bit.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
  localparam logic [7:0] DISARM_CODE = 8'h78;

  // control bit positions at ADDR_CTRL
  localparam int BIT_SWTRIG  = 0;
  localparam int BIT_HWEN    = 1;
  localparam int BIT_FREERUN = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic gateOpen;  // effective gate (flag masked by limit)
    logic counted;   // controlled acquisition: starts decrement the counter
    logic reload;    // mode write other than the disarm code
    logic disarm;    // mode write of the disarm code
  } ctlStrobe_t;
endpackage

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              trigRise,
  input  logic              limitIn,
  output ctlStrobe_t        strb,
  output logic [CNT_W-1:0]  loadVal
);
  logic hwEnQ, freeRunQ, gateQ;
  logic [CNT_W-1:0] countQ;
  logic ctrlWr, modeWr, cntWr, isDisarm;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign modeWr   = wrEn && (wrAddr == ADDR_MODE);
  assign cntWr    = wrEn && (wrAddr == ADDR_COUNT);
  assign isDisarm = (wrData[7:0] == DISARM_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwEnQ    <= 1'b0;
      freeRunQ <= 1'b0;
      countQ   <= '0;
    end else begin
      if (ctrlWr) begin
        hwEnQ    <= wrData[BIT_HWEN];
        freeRunQ <= wrData[BIT_FREERUN];
      end
      if (cntWr) countQ <= wrData[CNT_W-1:0];
    end
  end

  // gate flag: limit forces low, software clear next, then the set sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              gateQ <= 1'b0;
    else if (limitIn)                       gateQ <= 1'b0;
    else if (ctrlWr && !wrData[BIT_SWTRIG]) gateQ <= 1'b0;
    else if (ctrlWr && wrData[BIT_SWTRIG])  gateQ <= 1'b1;
    else if (trigRise && hwEnQ)             gateQ <= 1'b1;
  end

  always_comb begin
    strb.gateOpen = gateQ && !limitIn;
    strb.counted  = !freeRunQ;
    strb.reload   = modeWr && !isDisarm;
    strb.disarm   = modeWr && isDisarm;
  end
  assign loadVal = countQ;

  // R3: a high limit closes the gate flag by the next cycle
  a_r3_limit_closes_gate: assert property (@(posedge clk) disable iff (!rstN)
    limitIn |=> !gateQ);
  // R4: a software clear write closes the gate flag
  a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[BIT_SWTRIG]) |=> !gateQ);
endmodule

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pacerIn,
  input  logic             convInN,
  input  logic             trigIn,
  input  ctlStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             trigRise,
  output logic             limitOut,
  output logic             convStart
);
  localparam int NSRC = 3;
  localparam logic [NSRC-1:0] IDLE = 3'b011; // trig low, convert inputs high

  logic [NSRC-1:0] rawIn, fallV, riseV;
  logic [CNT_W-1:0] cntQ;
  logic startNext;

  assign rawIn = {trigIn, convInN, pacerIn};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    logic prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= {SYNC_STAGES{IDLE[g]}};
        prevQ <= IDLE[g];
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
        prevQ <= chain[SYNC_STAGES-1];
      end
    end
    assign fallV[g] = prevQ && !chain[SYNC_STAGES-1];
    assign riseV[g] = !prevQ && chain[SYNC_STAGES-1];
  end

  assign trigRise  = riseV[2];
  assign startNext = strb.gateOpen && (fallV[0] || fallV[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convStart <= 1'b0;
    else       convStart <= startNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitOut <= 1'b1;
      cntQ     <= '0;
    end else if (strb.disarm) begin
      limitOut <= 1'b1;
    end else if (strb.reload) begin
      limitOut <= 1'b0;
      cntQ     <= loadVal;
    end else if (startNext && strb.counted) begin
      if (cntQ <= CNT_W'(1)) begin
        limitOut <= 1'b1;
        cntQ     <= '0;
      end else begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  // R2: a start is only issued after a cycle with the gate open
  a_r2_start_needs_gate: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(strb.gateOpen));
  // R8: disarm code raises the limit, other mode codes lower it
  a_r8_disarm_raises: assert property (@(posedge clk) disable iff (!rstN)
    strb.disarm |=> limitOut);
  a_r8_reload_lowers: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> !limitOut);
  // R7: in free-run mode the limit never rises by itself
  a_r7_freerun_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.counted && !strb.disarm && !limitOut) |=> !limitOut);
endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
  import adc_trig_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pacerIn,
  input  logic              convInN,
  input  logic              trigIn,
  output logic              convStart,
  output logic              gateOpen,
  output logic              limitOut
);
  ctlStrobe_t strb;
  logic [CNT_W-1:0] loadVal;
  logic trigRise;

  adc_trig_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigRise(trigRise), .limitIn(limitOut), .strb(strb), .loadVal(loadVal)
  );

  adc_trig_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pacerIn(pacerIn), .convInN(convInN),
    .trigIn(trigIn), .strb(strb), .loadVal(loadVal), .trigRise(trigRise),
    .limitOut(limitOut), .convStart(convStart)
  );

  assign gateOpen = strb.gateOpen;
endmodule

// File: tb/sim_adc_trig_gate.sv
module sim_adc_trig_gate;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic pacerIn = 1'b1;
  logic convInN = 1'b1;
  logic trigIn = 1'b0;
  logic convStart, gateOpen, limitOut;

  int checks = 0;
  int errors = 0;
  int closeCnt = 0;
  int expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_gate #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pacerIn(pacerIn), .convInN(convInN), .trigIn(trigIn),
    .convStart(convStart), .gateOpen(gateOpen), .limitOut(limitOut)
  );

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: counts start cycles and compares each closed window to the queue
  initial begin
    int seen = 0;
    int handled = 0;
    forever begin
      @(negedge clk);
      if (convStart) seen++;
      if (closeCnt > handled) begin
        handled++;
        checkVal(tagQ.pop_front(), seen, expQ.pop_front());
        seen = 0;
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic [1:0] a, logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // which: 1 pacer, 2 convert, 3 both together
  task automatic fallPulse(int which);
    @(posedge clk); #1;
    if (which != 2) pacerIn = 1'b0;
    if (which != 1) convInN = 1'b0;
    tick(5);
    pacerIn = 1'b1; convInN = 1'b1;
    tick(5);
  endtask

  task automatic trigPulse();
    @(posedge clk); #1;
    trigIn = 1'b1;
    tick(5);
    trigIn = 1'b0;
    tick(5);
  endtask

  // driver side of the scoreboard: queue the expected start count
  task automatic closeWindow(int exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    closeCnt++;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic checkFlags(string tag, int g, int l);
    @(negedge clk);
    checkVal({tag, " gateOpen"}, int'(gateOpen), g);
    checkVal({tag, " limitOut"}, int'(limitOut), l);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    checkVal("R10 reset convStart", int'(convStart), 0);
    rstN = 1'b1;
    checkFlags("R10 reset", 0, 1);

    // R3: disarmed, software trigger and edges have no effect
    regWrite(2'd0, 16'h0003);
    checkFlags("R3 sw write while limit high", 0, 1);
    trigPulse();
    checkFlags("R3 trig while limit high", 0, 1);
    fallPulse(1);
    closeWindow(0, "R3 fall while disarmed");

    // R8 reload with count 3; gate still closed -> R2
    regWrite(2'd2, 16'd3);
    regWrite(2'd1, 16'h0010);
    checkFlags("R8 reload", 0, 0);
    fallPulse(1);
    closeWindow(0, "R2 fall with gate closed");

    // R5 open by software, then R1/R9/R7 controlled run of three
    regWrite(2'd0, 16'h0001);
    checkFlags("R5 sw open", 1, 0);
    fallPulse(1);
    closeWindow(1, "R1 pacer fall");
    fallPulse(2);
    closeWindow(1, "R1 convert fall");
    fallPulse(3);
    closeWindow(1, "R9 simultaneous falls");
    checkFlags("R7 count expired", 0, 1);
    fallPulse(2);
    closeWindow(0, "R7 fall after limit");

    // R6 hardware trigger qualified by its enable
    regWrite(2'd2, 16'd5);
    regWrite(2'd1, 16'h0001);
    regWrite(2'd0, 16'h0000);
    trigPulse();
    checkFlags("R6 trig with enable off", 0, 0);
    regWrite(2'd0, 16'h0002);
    trigPulse();
    checkFlags("R6 trig with enable on", 1, 0);
    fallPulse(1);
    closeWindow(1, "R6 start after hw trigger");
    regWrite(2'd0, 16'h0002);
    checkFlags("R4 sw clear", 0, 0);
    fallPulse(1);
    closeWindow(0, "R4 fall after sw clear");

    // R7 free-run: count of 1 does not stop it
    regWrite(2'd2, 16'd1);
    regWrite(2'd0, 16'h0007);
    regWrite(2'd1, 16'h0002);
    checkFlags("R7 free-run armed", 1, 0);
    fallPulse(1);
    fallPulse(2);
    fallPulse(1);
    closeWindow(3, "R7 free-run starts");
    checkFlags("R7 free-run no limit", 1, 0);

    // R8 disarm code
    regWrite(2'd1, 16'h0078);
    checkFlags("R8 disarm", 0, 1);
    trigPulse();
    checkFlags("R3 trig after disarm", 0, 1);
    fallPulse(3);
    closeWindow(0, "R8 fall after disarm");

    tick(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule